// File: doc/BRIEF.md
# Receive Character Queue with Clear-to-Send Threshold

This block sits between a UART receiver and the software or DMA reader of received characters. Characters arrive on a push strobe with an 8-bit data byte and leave on a pop strobe. The oldest held character is always presented on the pop data output. The queue holds 32 characters.

The block drives the active-low clear-to-send line from its fill level, so that the remote sender can be throttled. A programmable 6-bit trigger level sets the occupancy at which the line goes high ("stop sending"). Legal trigger levels are 0 to 32. Storage does not stop at the trigger: characters keep being accepted until all 32 slots are used. A character that arrives while the queue is full is discarded, and a sticky overrun flag records the loss until software clears it with a one-cycle pulse.

Top module: `rxq_cts_fifo`

## Requirements
- R1: After reset the queue is empty (empty=1, full=0), overrun=0, the trigger level is 32 and cts_n=0.
- R2: Characters leave in the order they arrived. While empty=0, pop_data shows the oldest held character, and a pop moves to the next one.
- R3: A push while full=1 discards the character, leaves the held contents and occupancy unchanged, and sets overrun at the next edge.
- R4: overrun stays at 1 until a cycle with ovr_clr=1 and no discarded push. When a discarded push and ovr_clr fall in the same cycle, overrun ends up at 1.
- R5: cts_n is 1 exactly when the occupancy is greater than or equal to the trigger level. It updates on the same clock edge as the occupancy or trigger change that causes it.
- R6: Pushes are still accepted while cts_n=1, until the occupancy reaches 32.
- R7: cts_n returns to 0 on the edge at which the occupancy falls below the trigger level.
- R8: A trigger write (trig_wr=1) loads trig_val. A value from 33 to 63 is reserved and is loaded as 32.
- R9: With a trigger level of 0, cts_n stays at 1 whatever the occupancy.
- R10: A pop while empty=1 has no effect. The queue stays empty, and the next pushed character is the next one popped.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged and keep the order.
- R12: full=1 exactly when 32 characters are held, and empty=1 exactly when none are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Write strobe for a received character |
| push_data | input | 8 | Received character |
| pop | input | 1 | Read strobe that removes the oldest character |
| pop_data | output | 8 | Oldest held character, valid while empty=0 |
| trig_wr | input | 1 | Load strobe for the trigger level |
| trig_val | input | 6 | New trigger level (0 to 32; 33 to 63 are loaded as 32) |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |
| cts_n | output | 1 | Clear-to-send, active low; 1 asks the sender to stop |
| full | output | 1 | All 32 slots hold characters |
| empty | output | 1 | No characters held |
| overrun | output | 1 | Sticky flag: a character was discarded |

## Verification
An occupancy count that is off by one shows at the ports in one of three ways. cts_n switches one character early or late against the trigger, full or empty appear at the wrong push, or the data drained after a full fill moves by one slot. Each of these is visible on the edge of the push or pop that caused it. A pointer that wraps wrongly shows in pop_data only after 32 characters have passed through, so the bench fills the queue completely and drains it. A trigger register that keeps a reserved value is invisible until the occupancy reaches 32. For that reason the reserved write is made on a full queue, where cts_n must stay high.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned RXQ_DATA_W = 8;
    localparam int unsigned RXQ_DEPTH  = 32;
    localparam int unsigned RXQ_TRIG_W = 6;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DATA_W-1:0] slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            ptr_d.wr_ptr = bump(ptr_q.wr_ptr);
        end
        if (rd_en) begin
            ptr_d.rd_ptr = bump(ptr_q.rd_ptr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (ptr_q.wr_ptr == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[ptr_q.rd_ptr];

    // R2: pointers never leave the storage range
    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(ptr_q.wr_ptr) < DEPTH) && (32'(ptr_q.rd_ptr) < DEPTH));
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             ovr_clr,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] cnt_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic             full,
    output logic             empty,
    output logic             overrun
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovr;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d   = lvl_q;
        full    = (lvl_q.cnt == CNT_W'(DEPTH));
        empty   = (lvl_q.cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        unique case ({push_ok, pop_ok})
            2'b10:   lvl_d.cnt = lvl_q.cnt + 1'b1;
            2'b01:   lvl_d.cnt = lvl_q.cnt - 1'b1;
            default: lvl_d.cnt = lvl_q.cnt;
        endcase
        if (push && full) begin
            lvl_d.ovr = 1'b1;
        end else if (ovr_clr) begin
            lvl_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign cnt_d   = lvl_d.cnt;
    assign cnt_q   = lvl_q.cnt;
    assign overrun = lvl_q.ovr;

    assert_flags_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= DEPTH);
    assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overrun);
    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/rxq_cts.sv
module rxq_cts #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned TRIG_W = 6,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_val,
    input  logic [CNT_W-1:0]  cnt_d,
    output logic [TRIG_W-1:0] trig_q,
    output logic              cts_n
);
    localparam logic [TRIG_W-1:0] TRIG_MAX = TRIG_W'(DEPTH);

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic              stop;
    } cts_t;

    cts_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (trig_wr) begin
            cs_d.trig = (32'(trig_val) > DEPTH) ? TRIG_MAX : trig_val;
        end
        cs_d.stop = (32'(cnt_d) >= 32'(cs_d.trig));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.trig <= TRIG_MAX;
            cs_q.stop <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign trig_q = cs_q.trig;
    assign cts_n  = cs_q.stop;

    assert_trig_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(trig_q) <= DEPTH);
    assert_zero_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q == '0) |-> cts_n);
endmodule

// File: rtl/rxq_cts_fifo.sv
module rxq_cts_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = RXQ_DATA_W,
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    parameter int unsigned TRIG_W = RXQ_TRIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_val,
    input  logic              ovr_clr,
    output logic              cts_n,
    output logic              full,
    output logic              empty,
    output logic              overrun
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             push_ok;
    logic             pop_ok;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;
    logic [TRIG_W-1:0] trig_q;

    rxq_level #(.DEPTH(DEPTH)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .ovr_clr (ovr_clr),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .cnt_d   (cnt_d),
        .cnt_q   (cnt_q),
        .full    (full),
        .empty   (empty),
        .overrun (overrun)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_data (push_data),
        .rd_en   (pop_ok),
        .rd_data (pop_data)
    );

    rxq_cts #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_wr  (trig_wr),
        .trig_val (trig_val),
        .cnt_d    (cnt_d),
        .trig_q   (trig_q),
        .cts_n    (cts_n)
    );

    assert_cts_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cts_n == (32'(cnt_q) >= 32'(trig_q)));
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(cnt_q)));
    assert_pass_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(cnt_q));
endmodule

// File: tb/sim_rxq_cts_fifo.sv
module sim_rxq_cts_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       trig_wr = 1'b0;
    logic [5:0] trig_val = '0;
    logic       ovr_clr = 1'b0;
    logic       cts_n, full, empty, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxq_cts_fifo u0 (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .trig_wr(trig_wr), .trig_val(trig_val),
        .ovr_clr(ovr_clr), .cts_n(cts_n), .full(full), .empty(empty),
        .overrun(overrun)
    );

    typedef struct packed {
        logic       push;
        logic [7:0] data;
        logic       pop;
        logic       twr;
        logic [5:0] tval;
        logic       clr;
        logic       e_cts;
        logic       e_full;
        logic       e_empty;
        logic       e_ovr;
        logic       ck_data;
        logic [7:0] e_data;
        logic [7:0] req;
    } vec_t;

    // Expected values sampled one half-period after the edge that applies the row.
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // push data   pop twr tval   clr cts full emp ovr ckd e_data  req
        '{1'b0, 8'h00, 1'b0, 1'b1, 6'd3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'd8},  // R8 load 3
        '{1'b1, 8'hA1, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1, 8'd2},  // R2
        '{1'b1, 8'hB2, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1, 8'd5},  // R5 below
        '{1'b1, 8'hC3, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1, 8'd5},  // R5 reach
        '{1'b1, 8'hD4, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1, 8'd6},  // R6
        '{1'b0, 8'h00, 1'b1, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB2, 8'd2},  // R2
        '{1'b0, 8'h00, 1'b1, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3, 8'd7},  // R7
        '{1'b1, 8'hE5, 1'b1, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD4, 8'd11}, // R11
        '{1'b0, 8'h00, 1'b0, 1'b1, 6'd50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD4, 8'd8},  // R8
        '{1'b0, 8'h00, 1'b0, 1'b1, 6'd2,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD4, 8'd5},  // R5 by trig
        '{1'b0, 8'h00, 1'b0, 1'b1, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD4, 8'd9},  // R9
        '{1'b0, 8'h00, 1'b1, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hE5, 8'd9},  // R9
        '{1'b0, 8'h00, 1'b1, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'd9},  // R9 empty
        '{1'b0, 8'h00, 1'b1, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'd10}, // R10
        '{1'b0, 8'h00, 1'b0, 1'b1, 6'd32, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'd12}  // R12
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #10;
    endtask

    task automatic idle_inputs();
        push = 1'b0; pop = 1'b0; trig_wr = 1'b0; ovr_clr = 1'b0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string rq;
        repeat (3) @(posedge clk);
        #10;
        // R1 reset state
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "overrun", int'(overrun), 0);
        chk("R1", "cts_n", int'(cts_n), 0);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NV; i++) begin
            push = VEC[i].push; push_data = VEC[i].data; pop = VEC[i].pop;
            trig_wr = VEC[i].twr; trig_val = VEC[i].tval; ovr_clr = VEC[i].clr;
            step();
            idle_inputs();
            rq = $sformatf("R%0d row%0d", VEC[i].req, i);
            chk(rq, "cts_n", int'(cts_n), int'(VEC[i].e_cts));
            chk(rq, "full", int'(full), int'(VEC[i].e_full));
            chk(rq, "empty", int'(empty), int'(VEC[i].e_empty));
            chk(rq, "overrun", int'(overrun), int'(VEC[i].e_ovr));
            if (VEC[i].ck_data) chk(rq, "pop_data", int'(pop_data), int'(VEC[i].e_data));
        end

        // R10: after empty pops, the next push is the next popped
        push = 1'b1; push_data = 8'h5A; step(); idle_inputs();
        chk("R10", "pop_data", int'(pop_data), 8'h5A);
        pop = 1'b1; step(); idle_inputs();
        chk("R10", "empty", int'(empty), 1);

        // R6 / R5: fill all 32 with trigger 32
        for (int i = 0; i < 32; i++) begin
            push = 1'b1; push_data = 8'(8'h10 + i); step(); idle_inputs();
            chk("R5", "cts_n during fill", int'(cts_n), (i == 31) ? 1 : 0);
            chk("R12", "full during fill", int'(full), (i == 31) ? 1 : 0);
        end
        chk("R6", "empty after fill", int'(empty), 0);

        // R8: reserved write on a full queue keeps cts_n high
        trig_wr = 1'b1; trig_val = 6'd63; step(); idle_inputs();
        chk("R8", "cts_n after reserved", int'(cts_n), 1);

        // R3: push while full is dropped
        push = 1'b1; push_data = 8'hEE; step(); idle_inputs();
        chk("R3", "overrun", int'(overrun), 1);
        chk("R3", "full", int'(full), 1);
        chk("R3", "pop_data", int'(pop_data), 8'h10);

        // R4: sticky, then clear, then set wins over clear
        step();
        chk("R4", "overrun held", int'(overrun), 1);
        ovr_clr = 1'b1; step(); idle_inputs();
        chk("R4", "overrun cleared", int'(overrun), 0);
        push = 1'b1; push_data = 8'hEF; ovr_clr = 1'b1; step(); idle_inputs();
        chk("R4", "set beats clear", int'(overrun), 1);

        // R2 / R7: drain and check order
        for (int i = 0; i < 32; i++) begin
            chk("R2", "drain data", int'(pop_data), 8'h10 + i);
            pop = 1'b1; step(); idle_inputs();
            chk("R7", "cts_n during drain", int'(cts_n), 0);
        end
        chk("R12", "empty after drain", int'(empty), 1);
        chk("R12", "full after drain", int'(full), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule